// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core that takes its instructions and its data from one shared memory port. A single ALU does all the arithmetic, including the program-counter step and the branch-target sum. A hardwired state machine moves each instruction through a fixed sequence of clock cycles. Each cycle leaves its partial result in an internal latch register: the instruction register, the X and Y operand latches, the Result latch and the memory-data latch.

The memory is combinational and has no wait states. The core drives an address, a read strobe, a write strobe and write data, and it samples the read data in the same cycle. The supported instruction classes are register add and subtract, add-immediate into a register, word load, word store and branch-if-equal. Each class takes its own fixed number of clocks.

Top module: `mc_cpu_core`

## Requirements
- R1: While reset is low and in the first cycle after it, the core is in its fetch cycle with PC = 0. All 32 registers read zero until they are written.
- R2: Every instruction starts with a fetch cycle. In that cycle `mem_rd` = 1, `mem_wr` = 0 and `mem_addr` = PC. The word read is the next instruction, and PC becomes PC+4.
- R3: The cycle after a fetch is a decode cycle with no memory access. It latches the registers selected by bits 25:21 (rs) and 20:16 (rt). An opcode in bits 31:26 outside the set below, or opcode 0 with a function code other than 32 or 34 or with bits 10:6 nonzero, returns to fetch after decode (2 clocks) and writes nothing.
- R4: Opcode 0 with function code (bits 5:0) 32 writes rs+rt into register bits 15:11 (rd). Function code 34 writes rs−rt there. Either takes 4 clocks.
- R5: Opcode 13 writes rs + sign-extended bits 15:0 into rt in 4 clocks.
- R6: Opcode 35 reads memory at rs + sign-extended bits 15:0. The read happens in its 4th cycle (`mem_rd` = 1) and rt receives the word. The instruction takes 5 clocks.
- R7: Opcode 43 writes rt to memory at rs + sign-extended bits 15:0. The write happens in its 4th and last cycle (`mem_wr` = 1, `mem_wdata` = rt).
- R8: Opcode 4 takes 3 clocks. If rs equals rt, the next fetch is at PC+4 + 4 × sign-extended bits 15:0. Otherwise it is at PC+4.
- R9: Register 0 always reads zero, and a write to it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address: PC in fetch, Result in data cycles |
| mem_rd | output | 1 | Read strobe for fetch and load |
| mem_wr | output | 1 | Write strobe for store |
| mem_wdata | output | 32 | Store data from the Y latch |
| mem_rdata | input | 32 | Read data, valid in the same cycle |

## Verification
A reference model steps through the program one instruction at a time. For each instruction it predicts the exact bus activity of every clock. The fetch cycle is due at the first falling edge after the previous instruction's last cycle. A load read is due in the 4th cycle and a store write in the 4th cycle. The next fetch therefore lands 2, 3, 4 or 5 clocks after the current one, depending on the class. The bench samples strobes, address and store data at each falling edge, so every class's length and every branch outcome shows up as a cycle or address mismatch. Register results are checked through later stores, including a closing store of each low register.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'd0;
   localparam logic [5:0] OPC_BEQ   = 6'd4;
   localparam logic [5:0] OPC_LDI   = 6'd13;
   localparam logic [5:0] OPC_LDW   = 6'd35;
   localparam logic [5:0] OPC_STW   = 6'd43;
   localparam logic [5:0] FN_ADD    = 6'd32;
   localparam logic [5:0] FN_SUB    = 6'd34;

   typedef enum logic [3:0] {
      ALU_ADD = 4'd2,
      ALU_SUB = 4'd6
   } alu_op_e;

   typedef enum logic [3:0] {
      ST_FETCH,
      ST_DECODE,
      ST_ALU_EXE,
      ST_IMM_EXE,
      ST_ADDR,
      ST_MEM_RD,
      ST_MEM_WR,
      ST_WB_ALU,
      ST_WB_IMM,
      ST_WB_MEM,
      ST_BRANCH
   } state_e;

   typedef enum logic {
      XS_PC,
      XS_REG
   } xsel_e;

   typedef enum logic [1:0] {
      YS_FOUR,
      YS_REG,
      YS_IMM,
      YS_OFS
   } ysel_e;

   typedef struct packed {
      logic    mem_rd;
      logic    mem_wr;
      logic    addr_res;
      logic    ir_ld;
      logic    pc_ld;
      logic    pc_ld_zero;
      logic    pc_from_res;
      logic    x_ld;
      logic    y_ld;
      logic    res_ld;
      logic    mdr_ld;
      logic    rf_we;
      logic    dst_rd;
      logic    wb_mdr;
      xsel_e   xsel;
      ysel_e   ysel;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/mcc_alu.sv
module mcc_alu
   import mcc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);

   if (W < 8) begin : g_bad_w
      $error("mcc_alu: W must be at least 8");
   end

   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
   parameter int unsigned W       = 32,
   parameter int unsigned DEPTH   = 32,
   parameter bit          R0_ZERO = 1'b1,
   localparam int unsigned AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata
);

   logic [W-1:0] regs [DEPTH];
   logic         wr_ok;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("mcc_regfile: DEPTH must be a power of two, at least 2");
   end

   if (R0_ZERO) begin : g_r0_hard
      assign wr_ok   = we && (waddr != '0);
      assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
      assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];
   end else begin : g_r0_plain
      assign wr_ok   = we;
      assign ra_data = regs[ra_addr];
      assign rb_data = regs[rb_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '{default: '0};
      end else if (wr_ok) begin
         regs[waddr] <= wdata;
      end
   end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
   import mcc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic [4:0] shamt,
   output state_e     state,
   output ctrl_t      ctl
);

   state_e st_q, st_d;
   logic   rtype_ok;

   assign rtype_ok = ((funct == FN_ADD) || (funct == FN_SUB)) && (shamt == 5'd0);
   assign state    = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_FETCH;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d = ST_FETCH;
      unique case (st_q)
         ST_FETCH:   st_d = ST_DECODE;
         ST_DECODE: begin
            unique case (opcode)
               OPC_RTYPE:        st_d = rtype_ok ? ST_ALU_EXE : ST_FETCH;
               OPC_LDI:          st_d = ST_IMM_EXE;
               OPC_LDW, OPC_STW: st_d = ST_ADDR;
               OPC_BEQ:          st_d = ST_BRANCH;
               default:          st_d = ST_FETCH;
            endcase
         end
         ST_ALU_EXE: st_d = ST_WB_ALU;
         ST_IMM_EXE: st_d = ST_WB_IMM;
         ST_ADDR:    st_d = (opcode == OPC_LDW) ? ST_MEM_RD : ST_MEM_WR;
         ST_MEM_RD:  st_d = ST_WB_MEM;
         default:    st_d = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl.mem_rd      = 1'b0;
      ctl.mem_wr      = 1'b0;
      ctl.addr_res    = 1'b0;
      ctl.ir_ld       = 1'b0;
      ctl.pc_ld       = 1'b0;
      ctl.pc_ld_zero  = 1'b0;
      ctl.pc_from_res = 1'b0;
      ctl.x_ld        = 1'b0;
      ctl.y_ld        = 1'b0;
      ctl.res_ld      = 1'b0;
      ctl.mdr_ld      = 1'b0;
      ctl.rf_we       = 1'b0;
      ctl.dst_rd      = 1'b0;
      ctl.wb_mdr      = 1'b0;
      ctl.xsel        = XS_REG;
      ctl.ysel        = YS_REG;
      ctl.alu_op      = ALU_ADD;
      unique case (st_q)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_ld  = 1'b1;
            ctl.xsel   = XS_PC;
            ctl.ysel   = YS_FOUR;
            ctl.pc_ld  = 1'b1;
         end
         ST_DECODE: begin
            ctl.x_ld   = 1'b1;
            ctl.y_ld   = 1'b1;
            ctl.xsel   = XS_PC;
            ctl.ysel   = YS_OFS;
            ctl.res_ld = 1'b1;
         end
         ST_ALU_EXE: begin
            ctl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
            ctl.res_ld = 1'b1;
         end
         ST_IMM_EXE, ST_ADDR: begin
            ctl.ysel   = YS_IMM;
            ctl.res_ld = 1'b1;
         end
         ST_MEM_RD: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_res = 1'b1;
            ctl.mdr_ld   = 1'b1;
         end
         ST_MEM_WR: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_res = 1'b1;
         end
         ST_WB_ALU: begin
            ctl.rf_we  = 1'b1;
            ctl.dst_rd = 1'b1;
         end
         ST_WB_IMM: ctl.rf_we = 1'b1;
         ST_WB_MEM: begin
            ctl.rf_we  = 1'b1;
            ctl.wb_mdr = 1'b1;
         end
         ST_BRANCH: begin
            ctl.alu_op      = ALU_SUB;
            ctl.pc_ld_zero  = 1'b1;
            ctl.pc_from_res = 1'b1;
         end
         default: ;
      endcase
   end

   // cycle index within the current instruction, kept apart from the state register
   logic [2:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 len_q <= 3'd1;
      else if (st_d == ST_FETCH)  len_q <= 3'd1;
      else                        len_q <= len_q + 3'd1;
   end

   AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_FETCH) |=> (st_q == ST_DECODE)); // R2
   AST_ALU_LEN:    assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WB_ALU) |-> (len_q == 3'd4)); // R4
   AST_IMM_LEN:    assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WB_IMM) |-> (len_q == 3'd4)); // R5
   AST_LOAD_LEN:   assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WB_MEM) |-> (len_q == 3'd5)); // R6
   AST_STORE_LEN:  assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_MEM_WR) |-> (len_q == 3'd4)); // R7
   AST_BRANCH_LEN: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_BRANCH) |-> (len_q == 3'd3)); // R8

endmodule

// File: rtl/mc_cpu_core.sv
module mc_cpu_core
   import mcc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned RF_DEPTH = 32,
   parameter logic [DATA_W-1:0] RESET_PC = '0,
   parameter bit          R0_ZERO  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DATA_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int unsigned RF_AW = $clog2(RF_DEPTH);
   localparam logic [DATA_W-1:0] PC_STEP = {{(DATA_W-3){1'b0}}, 3'd4};

   if (DATA_W != 32) begin : g_bad_width
      $error("mc_cpu_core: the instruction format fixes DATA_W at 32");
   end
   if (RF_DEPTH > 32) begin : g_bad_depth
      $error("mc_cpu_core: register fields are 5 bits, RF_DEPTH at most 32");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("mc_cpu_core: RESET_PC must be word aligned");
   end

   state_e state;
   ctrl_t  ctl;

   logic [DATA_W-1:0] pc_q, ir_q, x_q, y_q, res_q, mdr_q;
   logic [DATA_W-1:0] alu_a, alu_b, alu_y;
   logic              alu_zero;
   logic [DATA_W-1:0] imm_sx, ofs_sh;
   logic [DATA_W-1:0] rf_ra, rf_rb, rf_wdata;
   logic [4:0]        rs_f, rt_f, rd_f, wb_f;

   assign rs_f   = ir_q[25:21];
   assign rt_f   = ir_q[20:16];
   assign rd_f   = ir_q[15:11];
   assign imm_sx = {{(DATA_W-16){ir_q[15]}}, ir_q[15:0]};
   assign ofs_sh = {imm_sx[DATA_W-3:0], 2'b00};

   mcc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir_q[31:26]),
      .funct  (ir_q[5:0]),
      .shamt  (ir_q[10:6]),
      .state  (state),
      .ctl    (ctl)
   );

   always_comb begin
      unique case (ctl.xsel)
         XS_PC:   alu_a = pc_q;
         default: alu_a = x_q;
      endcase
      unique case (ctl.ysel)
         YS_FOUR: alu_b = PC_STEP;
         YS_REG:  alu_b = y_q;
         YS_IMM:  alu_b = imm_sx;
         default: alu_b = ofs_sh;
      endcase
   end

   mcc_alu #(.W(DATA_W)) u_alu (
      .a    (alu_a),
      .b    (alu_b),
      .op   (ctl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign wb_f     = ctl.dst_rd ? rd_f : rt_f;
   assign rf_wdata = ctl.wb_mdr ? mdr_q : res_q;

   mcc_regfile #(.W(DATA_W), .DEPTH(RF_DEPTH), .R0_ZERO(R0_ZERO)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (rs_f[RF_AW-1:0]),
      .ra_data (rf_ra),
      .rb_addr (rt_f[RF_AW-1:0]),
      .rb_data (rf_rb),
      .we      (ctl.rf_we),
      .waddr   (wb_f[RF_AW-1:0]),
      .wdata   (rf_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         ir_q  <= '0;
         x_q   <= '0;
         y_q   <= '0;
         res_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ctl.pc_ld || (ctl.pc_ld_zero && alu_zero))
            pc_q <= ctl.pc_from_res ? res_q : alu_y;
         if (ctl.ir_ld)  ir_q  <= mem_rdata;
         if (ctl.x_ld)   x_q   <= rf_ra;
         if (ctl.y_ld)   y_q   <= rf_rb;
         if (ctl.res_ld) res_q <= alu_y;
         if (ctl.mdr_ld) mdr_q <= mem_rdata;
      end
   end

   assign mem_addr  = ctl.addr_res ? res_q : pc_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign mem_wdata = y_q;

   AST_RESET_FETCH:  assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (mem_rd && mem_addr == RESET_PC)); // R1
   AST_PC_STEP:      assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_STEP)); // R2
   AST_QUIET_DECODE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_DECODE) |-> (!mem_rd && !mem_wr && !ctl.rf_we)); // R3
   AST_LOAD_WB:      assert property (@(posedge clk) disable iff (!rst_n) (state == ST_MEM_RD) |=> (ctl.rf_we && rf_wdata == $past(mem_rdata))); // R6
   AST_ONE_MEM_OP:   assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R7
   AST_BR_TAKEN:     assert property (@(posedge clk) disable iff (!rst_n) (state == ST_BRANCH && x_q == y_q) |=> (pc_q == $past(res_q))); // R8
   AST_BR_FALL:      assert property (@(posedge clk) disable iff (!rst_n) (state == ST_BRANCH && x_q != y_q) |=> $stable(pc_q)); // R8

   if (R0_ZERO) begin : g_r0_chk
      AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_DECODE && rs_f == 5'd0) |=> (x_q == '0)); // R9
   end

endmodule

// File: tb/mc_cpu_core_bench.sv
module mc_cpu_core_bench;

   localparam int unsigned WATCHDOG = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr;
   logic [31:0] mem [256];

   always #4 clk = ~clk;

   assign mem_rdata = mem[mem_addr[9:2]];

   mc_cpu_core u_mc_cpu_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;
   logic [31:0] m_reg [32];
   logic [31:0] m_mem [256];
   string       m_tag [32];
   logic [31:0] m_pc;
   string       nxt_tag;

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
      return {6'd0, rs, rt, rd, 5'd0, fn};
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one clock: compare the bus, apply a store, move to the next falling edge
   task automatic cyc(string req, logic e_rd, logic e_wr, bit chk_a, logic [31:0] e_a, bit chk_d, logic [31:0] e_d);
      check(req, "mem_rd", {31'd0, mem_rd}, {31'd0, e_rd});
      check(req, "mem_wr", {31'd0, mem_wr}, {31'd0, e_wr});
      if (chk_a) check(req, "mem_addr", mem_addr, e_a);
      if (chk_d) check(req, "mem_wdata", mem_wdata, e_d);
      if (mem_wr) mem[mem_addr[9:2]] = mem_wdata;
      @(negedge clk);
   endtask

   task automatic put(int idx, logic [31:0] w);
      m_mem[idx] = w;
      mem[idx]   = w;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         m_mem[i] = '0;
         mem[i]   = '0;
      end
   endtask

   task automatic step();
      logic [31:0] ins = m_mem[m_pc[9:2]];
      logic [5:0]  op  = ins[31:26];
      logic [4:0]  rs  = ins[25:21];
      logic [4:0]  rt  = ins[20:16];
      logic [4:0]  rd  = ins[15:11];
      logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] ea  = m_reg[rs] + sx;
      cyc(nxt_tag, 1'b1, 1'b0, 1'b1, m_pc, 1'b0, '0);
      m_pc = m_pc + 32'd4;
      if (op == 6'd0 && (ins[5:0] == 6'd32 || ins[5:0] == 6'd34) && ins[10:6] == 5'd0) begin
         repeat (3) cyc("R4", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         if (rd != 5'd0) begin
            m_reg[rd] = (ins[5:0] == 6'd34) ? m_reg[rs] - m_reg[rt] : m_reg[rs] + m_reg[rt];
            m_tag[rd] = "R4";
         end
         nxt_tag = "R4";
      end else if (op == 6'd13) begin
         repeat (3) cyc("R5", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         if (rt != 5'd0) begin
            m_reg[rt] = m_reg[rs] + sx;
            m_tag[rt] = "R5";
         end
         nxt_tag = "R5";
      end else if (op == 6'd35) begin
         repeat (2) cyc("R6", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         cyc("R6", 1'b1, 1'b0, 1'b1, ea, 1'b0, '0);
         cyc("R6", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         if (rt != 5'd0) begin
            m_reg[rt] = m_mem[ea[9:2]];
            m_tag[rt] = "R6";
         end
         nxt_tag = "R6";
      end else if (op == 6'd43) begin
         repeat (2) cyc("R7", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         cyc(m_tag[rt], 1'b0, 1'b1, 1'b1, ea, 1'b1, m_reg[rt]);
         m_mem[ea[9:2]] = m_reg[rt];
         nxt_tag = "R7";
      end else if (op == 6'd4) begin
         repeat (2) cyc("R8", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         if (m_reg[rs] == m_reg[rt]) m_pc = m_pc + {sx[29:0], 2'b00};
         nxt_tag = "R8";
      end else begin
         cyc("R3", 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
         nxt_tag = "R3";
      end
   endtask

   task automatic run_prog(int end_idx);
      rst_n = 1'b0;
      for (int i = 0; i < 32; i++) begin
         m_reg[i] = '0;
         m_tag[i] = "R1";
      end
      m_tag[0] = "R9";
      m_pc     = '0;
      nxt_tag  = "R1";
      repeat (2) begin
         @(negedge clk);
         check("R1", "reset mem_rd", {31'd0, mem_rd}, 32'd1);
         check("R1", "reset mem_wr", {31'd0, mem_wr}, 32'd0);
         check("R1", "reset mem_addr", mem_addr, 32'd0);
      end
      rst_n = 1'b1;
      for (int k = 0; k < 5000 && m_pc != 32'(end_idx * 4); k++) step();
      cyc(nxt_tag, 1'b1, 1'b0, 1'b1, 32'(end_idx * 4), 1'b0, '0);
   endtask

   task automatic load_directed();
      clear_mem();
      put(0,  enc_i(6'd13, 5'd0,  5'd31, 16'd512));
      put(1,  enc_i(6'd13, 5'd0,  5'd1,  16'd2));
      put(2,  enc_i(6'd13, 5'd1,  5'd1,  16'hFFFF));   // R5 negative immediate
      put(3,  enc_i(6'd43, 5'd31, 5'd1,  16'd0));
      put(4,  enc_i(6'd4,  5'd1,  5'd0,  16'd1));      // R8 forward when equal
      put(5,  enc_i(6'd4,  5'd0,  5'd0,  16'hFFFC));   // R8 backward, always taken
      put(6,  enc_r(5'd0,  5'd31, 5'd2,  6'd34));      // R4 subtract to negative
      put(7,  enc_i(6'd43, 5'd31, 5'd2,  16'd4));
      put(8,  enc_i(6'd35, 5'd31, 5'd3,  16'd4));      // R6
      put(9,  enc_r(5'd3,  5'd3,  5'd4,  6'd32));
      put(10, enc_i(6'd43, 5'd31, 5'd4,  16'hFFFC));   // R7 negative offset
      put(11, enc_r(5'd31, 5'd31, 5'd0,  6'd32));      // R9 write to register 0
      put(12, enc_i(6'd43, 5'd31, 5'd0,  16'd8));
      put(13, 32'hFC00_0000);                          // R3 unknown opcode
      put(14, enc_r(5'd31, 5'd31, 5'd5,  6'd36));      // R3 unknown function
      put(15, enc_i(6'd43, 5'd31, 5'd5,  16'd12));
      put(16, enc_i(6'd4,  5'd0,  5'd0,  16'hFFFF));
   endtask

   task automatic load_random(int n);
      clear_mem();
      put(0, enc_i(6'd13, 5'd0, 5'd31, 16'd512));
      for (int i = 1; i < n - 17; i++) begin
         int unsigned sel = $urandom_range(0, 99);
         logic [4:0] ra = 5'($urandom_range(0, 15));
         logic [4:0] rb = 5'($urandom_range(0, 15));
         logic [4:0] rc = 5'($urandom_range(0, 15));
         logic [15:0] mo = 16'((int'($urandom_range(0, 80)) - 16) * 4);
         if (sel < 25)
            put(i, enc_r(ra, rb, rc, ($urandom_range(0, 1) == 0) ? 6'd32 : 6'd34));
         else if (sel < 45)
            put(i, enc_i(6'd13, ($urandom_range(0, 3) == 0) ? 5'd31 : ra, rc, 16'($urandom)));
         else if (sel < 60)
            put(i, enc_i(6'd35, 5'd31, rc, mo));
         else if (sel < 80)
            put(i, enc_i(6'd43, 5'd31, rb, mo));
         else if (sel < 92) begin
            int mx = n - 2 - i;
            int of = int'($urandom_range(0, 3));
            if (of > mx) of = mx;
            put(i, enc_i(6'd4, 5'(ra[1:0]), ($urandom_range(0, 2) == 0) ? 5'(ra[1:0]) : 5'(rb[1:0]), 16'(of)));
         end else if (sel < 96)
            put(i, {6'd50 + 6'($urandom_range(0, 7)), 26'($urandom)});
         else
            put(i, enc_r(ra, rb, rc, 6'd37));
      end
      for (int k = 0; k < 16; k++)
         put(n - 17 + k, enc_i(6'd43, 5'd31, 5'(k), 16'(k * 4)));
      put(n - 1, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF));
   endtask

   initial begin
      void'($urandom(32'h00C0_FFEE));
      load_directed();
      run_prog(16);
      for (int p = 0; p < 4; p++) begin
         load_random(100);
         run_prog(99);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule